// File: doc/BRIEF.md
# Miss-Capped Shared Store Write Buffer

The block is a store write buffer that several hardware threads share. It sits between the point where stores retire and a level-one data cache. Each completed store arrives with a thread number, an address and data. In the same cycle the block sends the line address to the cache as a probe, and the cache answers at once with hit or miss. A store whose line is resident is held as ready and leaves through the write port, normally on the next cycle. A store whose line is absent is held as pending. It stays in the buffer until the fill logic returns that line.

Misses can take hundreds of cycles. Without a bound, they could take every slot and block stores that would drain at once. The block therefore counts how many of its entries are waiting on a fill. A programmable cap bounds that count. A missing store that would exceed the cap is refused with backpressure. A hitting store is taken whenever any slot is free.

The write port drains at most one ready entry per cycle and always takes the oldest eligible one. Two stores from the same thread to the same address leave in the order they arrived.

Top module: `mcsb_top`

## Requirements
- R1: After reset the buffer is empty, `wr_valid` is low, the cap equals DEPTH, and `st_ready` is high.
- R2: An accepted store with `pr_hit` high is written out on the write port (`wr_valid` with its thread, address and data) two clock edges after the accepting edge, when nothing older competes.
- R3: An accepted store with `pr_hit` low is not written out until a `fill_valid` carrying its line address (`addr[ADDR_W-1:LINE_OFF]`) arrives. It then appears on the write port two edges after the fill edge.
- R4: While the number of fill-waiting entries equals the cap, a store with `pr_hit` low sees `st_ready` low. A store with `pr_hit` high is still accepted and drains.
- R5: A write of `cfg_cap_val` with `cfg_cap_we` high sets the cap. The value 0 is taken as 1, and values above DEPTH are taken as DEPTH.
- R6: One fill releases every waiting entry whose line matches. The waiting count drops by that number, so the same number of new misses is accepted afterwards.
- R7: At most one entry drains per cycle. Among ready entries the oldest drains first, so entries released together drain on consecutive cycles in arrival order.
- R8: An entry may not drain while an older entry of the same thread with the same full address is still buffered. Entries of other threads to that address are not held back.
- R9: When all DEPTH slots are occupied, `st_ready` is low even for a hitting store.
- R10: A missing store whose line equals the fill line in the same cycle is accepted even at the cap. It is stored ready, drains as a hit would, and does not add to the waiting count.
- R11: A slot freed by a drain can be allocated on the very next cycle. With a full buffer, `st_ready` rises the cycle after the drain edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cap_we | input | 1 | Load the miss cap |
| cfg_cap_val | input | CNT_W | New miss cap, clamped to 1..DEPTH |
| st_valid | input | 1 | Completed store offered |
| st_ready | output | 1 | Store accepted this cycle when valid |
| st_tid | input | TID_W | Thread number of the store |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| pr_req | output | 1 | Cache probe request |
| pr_line | output | LINE_W | Line address probed |
| pr_hit | input | 1 | Probe result, same cycle |
| fill_valid | input | 1 | A line has been filled into the cache |
| fill_line | input | LINE_W | Line address of the fill |
| wr_valid | output | 1 | Cache write this cycle |
| wr_tid | output | TID_W | Thread of the written store |
| wr_addr | output | ADDR_W | Address written |
| wr_data | output | DATA_W | Data written |

## Verification
A single hitting store measures the bare drain latency. A single missing store shows that nothing leaves before its fill, and it gives the latency counted from the fill. Mixes of misses and hits run against a lowered cap, the clamped cap values and a full buffer. These separate refusal caused by the miss count from refusal caused by a lack of slots, and they show whether hits keep flowing. Three misses to one line released by a single fill expose the oldest-first order and the recovered count. An older miss followed by same-address hits from its own thread and from another thread shows that only the same thread is held back. A miss that coincides with its own fill checks the bypass path.

// File: rtl/mcsb_pkg.sv
package mcsb_pkg;
  // how an accepted store is entered into the buffer
  typedef enum logic [1:0] {
    ALLOC_NONE   = 2'd0,
    ALLOC_HIT    = 2'd1,
    ALLOC_MISS   = 2'd2,
    ALLOC_FILLED = 2'd3
  } alloc_kind_e;
endpackage

// File: rtl/mcsb_free_pick.sv
module mcsb_free_pick #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic [DEPTH-1:0] busy,
  output logic             free_any,
  output logic [IDX_W-1:0] free_idx
);
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mcsb_drain_pick.sv
module mcsb_drain_pick #(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3,
  parameter int TID_W  = 2,
  parameter int ADDR_W = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [DEPTH-1:0]                  valid,
  input  logic [DEPTH-1:0]                  pend,
  input  logic [DEPTH-1:0][TID_W-1:0]       tid,
  input  logic [DEPTH-1:0][ADDR_W-1:0]      addr,
  input  logic [DEPTH-1:0][DEPTH-1:0]       older,   // older[j][i]: j came before i
  output logic [DEPTH-1:0]                  grant,
  output logic                              grant_any,
  output logic [IDX_W-1:0]                  grant_idx
);
  logic [DEPTH-1:0] blocked;
  logic [DEPTH-1:0] cand;

  always_comb begin
    blocked = '0;
    for (int i = 0; i < DEPTH; i++) begin
      for (int j = 0; j < DEPTH; j++) begin
        if (j != i && valid[j] && older[j][i] && tid[j] == tid[i] && addr[j] == addr[i])
          blocked[i] = 1'b1;
      end
    end
    cand = valid & ~pend & ~blocked;
    grant = '0;
    for (int i = 0; i < DEPTH; i++) begin
      grant[i] = cand[i];
      for (int j = 0; j < DEPTH; j++) begin
        if (j != i && cand[j] && older[j][i]) grant[i] = 1'b0;
      end
    end
    grant_any = |grant;
    grant_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (grant[i]) grant_idx = IDX_W'(i);
    end
  end

  // R7: the write port serves one entry at most
  p_one_drain_r7: assert property (@(posedge clk) disable iff (rst) $onehot0(grant))
    else $error("more than one entry granted");
endmodule

// File: rtl/mcsb_miss_counter.sv
module mcsb_miss_counter #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic [CNT_W-1:0] dec,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + CNT_W'(inc) - dec;
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst) count <= CNT_W'(DEPTH))
    else $error("waiting count above depth");
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst) dec <= count)
    else $error("more releases than waiting entries");
endmodule

// File: rtl/mcsb_top.sv
module mcsb_top
  import mcsb_pkg::*;
#(
  parameter int  DEPTH    = 8,
  parameter int  TID_W    = 2,
  parameter int  ADDR_W   = 32,
  parameter int  DATA_W   = 32,
  parameter int  LINE_OFF = 6,
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int LINE_W   = ADDR_W - LINE_OFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cap_we,
  input  logic [CNT_W-1:0]  cfg_cap_val,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [TID_W-1:0]  st_tid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              pr_req,
  output logic [LINE_W-1:0] pr_line,
  input  logic              pr_hit,
  input  logic              fill_valid,
  input  logic [LINE_W-1:0] fill_line,
  output logic              wr_valid,
  output logic [TID_W-1:0]  wr_tid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  // entry state
  logic [DEPTH-1:0]              valid_q;
  logic [DEPTH-1:0]              pend_q;
  logic [DEPTH-1:0][TID_W-1:0]   tid_q;
  logic [DEPTH-1:0][ADDR_W-1:0]  addr_q;
  logic [DEPTH-1:0][DEPTH-1:0]   older_q;
  logic [DATA_W-1:0]             data_mem [DEPTH];
  logic [CNT_W-1:0]              cap_q;

  logic             free_any;
  logic [IDX_W-1:0] free_idx;
  logic [DEPTH-1:0] grant;
  logic             grant_any;
  logic [IDX_W-1:0] grant_idx;
  logic [CNT_W-1:0] miss_cnt;
  logic [CNT_W-1:0] fill_dec;
  logic [DEPTH-1:0] fill_match;
  logic             fill_bypass;
  logic             accept;
  alloc_kind_e      alloc_kind;

  assign pr_req      = st_valid;
  assign pr_line     = st_addr[ADDR_W-1:LINE_OFF];
  assign fill_bypass = fill_valid && (fill_line == st_addr[ADDR_W-1:LINE_OFF]);
  assign st_ready    = free_any && (pr_hit || fill_bypass || (miss_cnt < cap_q));
  assign accept      = st_valid && st_ready;

  always_comb begin
    if (!accept)          alloc_kind = ALLOC_NONE;
    else if (pr_hit)      alloc_kind = ALLOC_HIT;
    else if (fill_bypass) alloc_kind = ALLOC_FILLED;
    else                  alloc_kind = ALLOC_MISS;
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      fill_match[i] = valid_q[i] && pend_q[i] && fill_valid &&
                      (addr_q[i][ADDR_W-1:LINE_OFF] == fill_line);
    fill_dec = CNT_W'($countones(fill_match));
  end

  mcsb_free_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_free (
    .busy(valid_q), .free_any(free_any), .free_idx(free_idx)
  );

  mcsb_drain_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W), .TID_W(TID_W), .ADDR_W(ADDR_W)) u_drain (
    .clk(clk), .rst(rst), .valid(valid_q), .pend(pend_q), .tid(tid_q), .addr(addr_q),
    .older(older_q), .grant(grant), .grant_any(grant_any), .grant_idx(grant_idx)
  );

  mcsb_miss_counter #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(alloc_kind == ALLOC_MISS), .dec(fill_dec), .count(miss_cnt)
  );

  // cap register, clamped into 1..DEPTH
  always_ff @(posedge clk) begin
    if (rst) cap_q <= CNT_W'(DEPTH);
    else if (cfg_cap_we) begin
      if (cfg_cap_val == '0)                 cap_q <= CNT_W'(1);
      else if (cfg_cap_val > CNT_W'(DEPTH))  cap_q <= CNT_W'(DEPTH);
      else                                   cap_q <= cfg_cap_val;
    end
  end

  // control state and registered write port
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      pend_q   <= '0;
      wr_valid <= 1'b0;
      wr_tid   <= '0;
      wr_addr  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (grant[i])      valid_q[i] <= 1'b0;
        if (fill_match[i]) pend_q[i]  <= 1'b0;
      end
      if (alloc_kind != ALLOC_NONE) begin
        valid_q[free_idx] <= 1'b1;
        pend_q[free_idx]  <= (alloc_kind == ALLOC_MISS);
        tid_q[free_idx]   <= st_tid;
        addr_q[free_idx]  <= st_addr;
        for (int j = 0; j < DEPTH; j++) begin
          older_q[free_idx][j] <= 1'b0;
          if (j != int'(free_idx)) older_q[j][free_idx] <= 1'b1;
        end
      end
      wr_valid <= grant_any;
      if (grant_any) begin
        wr_tid  <= tid_q[grant_idx];
        wr_addr <= addr_q[grant_idx];
      end
    end
  end

  // data storage: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (accept) data_mem[free_idx] <= st_data;
    wr_data <= data_mem[grant_idx];
  end

  // R6: the counter agrees with the pending flags
  p_count_tracks_r6: assert property (@(posedge clk) disable iff (rst)
    miss_cnt == CNT_W'($countones(valid_q & pend_q)))
    else $error("waiting count out of step");
  // R4: a new waiting entry only below the cap
  p_cap_respected_r4: assert property (@(posedge clk) disable iff (rst)
    (alloc_kind == ALLOC_MISS) |-> (miss_cnt < cap_q))
    else $error("miss accepted at cap");
  // R5: cap stays in range
  p_cap_range_r5: assert property (@(posedge clk) disable iff (rst)
    (cap_q != '0) && (cap_q <= CNT_W'(DEPTH)))
    else $error("cap out of range");
  // R2: a grant reaches the write port on the next edge
  p_drain_reg_r2: assert property (@(posedge clk) disable iff (rst)
    grant_any |=> wr_valid)
    else $error("grant lost");
  // R9: a full buffer takes nothing
  p_full_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (&valid_q) |-> !accept)
    else $error("accept while full");
endmodule

// File: tb/mcsb_top_tb.sv
module mcsb_top_tb_top;
  localparam int DEPTH = 8;
  localparam int CNT_W = 4;
  localparam int LINE_W = 26;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_cap_we = 1'b0;
  logic [CNT_W-1:0] cfg_cap_val = '0;
  logic st_valid = 1'b0;
  logic st_ready;
  logic [1:0] st_tid = '0;
  logic [31:0] st_addr = '0;
  logic [31:0] st_data = '0;
  logic pr_req;
  logic [LINE_W-1:0] pr_line;
  logic pr_hit = 1'b0;
  logic fill_valid = 1'b0;
  logic [LINE_W-1:0] fill_line = '0;
  logic wr_valid;
  logic [1:0] wr_tid;
  logic [31:0] wr_addr;
  logic [31:0] wr_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nlog = 0;
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];
  logic [1:0]  log_tid  [64];
  int          log_cyc  [64];
  int          last_cyc;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  mcsb_top dut_i (
    .clk(clk), .rst(rst), .cfg_cap_we(cfg_cap_we), .cfg_cap_val(cfg_cap_val),
    .st_valid(st_valid), .st_ready(st_ready), .st_tid(st_tid), .st_addr(st_addr),
    .st_data(st_data), .pr_req(pr_req), .pr_line(pr_line), .pr_hit(pr_hit),
    .fill_valid(fill_valid), .fill_line(fill_line), .wr_valid(wr_valid),
    .wr_tid(wr_tid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && wr_valid && nlog < 64) begin
      log_addr[nlog] = wr_addr;
      log_data[nlog] = wr_data;
      log_tid[nlog]  = wr_tid;
      log_cyc[nlog]  = cyc;
      nlog = nlog + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive one store for one edge; optionally a fill in the same cycle
  task automatic offer(input logic [1:0] tid, input logic [31:0] addr, input logic [31:0] data,
                       input bit hit, input bit exp_rdy, input string req,
                       input bit with_fill, input logic [LINE_W-1:0] fl);
    st_valid = 1'b1; st_tid = tid; st_addr = addr; st_data = data; pr_hit = hit;
    fill_valid = with_fill; fill_line = fl;
    #1;
    chk(st_ready == exp_rdy, req, st_ready, exp_rdy);
    last_cyc = cyc;
    @(posedge clk);
    @(negedge clk);
    st_valid = 1'b0; pr_hit = 1'b0; fill_valid = 1'b0;
  endtask

  task automatic push(input logic [1:0] tid, input logic [31:0] addr, input logic [31:0] data,
                      input bit hit, input bit exp_rdy, input string req);
    offer(tid, addr, data, hit, exp_rdy, req, 1'b0, '0);
  endtask

  task automatic fill(input logic [31:0] addr);
    fill_valid = 1'b1; fill_line = addr[31:6];
    last_cyc = cyc;
    @(posedge clk);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic set_cap(input logic [CNT_W-1:0] v);
    cfg_cap_we = 1'b1; cfg_cap_val = v;
    @(posedge clk);
    @(negedge clk);
    cfg_cap_we = 1'b0;
  endtask

  task automatic t_reset();
    // R1
    chk(wr_valid == 1'b0, "R1 wr_valid", wr_valid, 0);
    chk(st_ready == 1'b1, "R1 st_ready", st_ready, 1);
  endtask

  task automatic t_hit();
    int n0;
    int a;
    n0 = nlog;
    push(2'd1, 32'h1000, 32'hA1, 1'b1, 1'b1, "R2 accept");
    a = last_cyc;
    idle(3);
    chk(nlog == n0 + 1, "R2 count", nlog - n0, 1);
    chk(log_addr[n0] == 32'h1000 && log_data[n0] == 32'hA1 && log_tid[n0] == 2'd1,
        "R2 content", log_data[n0], 32'hA1);
    chk(log_cyc[n0] - a == 2, "R2 latency", log_cyc[n0] - a, 2);
  endtask

  task automatic t_miss();
    int n0;
    int f;
    n0 = nlog;
    push(2'd2, 32'h2000, 32'hB2, 1'b0, 1'b1, "R3 accept");
    idle(6);
    chk(nlog == n0, "R3 held", nlog - n0, 0);
    fill(32'h2000);
    f = last_cyc;
    idle(3);
    chk(nlog == n0 + 1 && log_addr[n0] == 32'h2000 && log_data[n0] == 32'hB2,
        "R3 drained", log_addr[n0], 32'h2000);
    chk(log_cyc[n0] - f == 2, "R3 latency", log_cyc[n0] - f, 2);
  endtask

  task automatic t_cap();
    int n0;
    set_cap(4'd2);
    push(2'd0, 32'h3000, 32'h30, 1'b0, 1'b1, "R4 miss1");
    push(2'd0, 32'h3040, 32'h31, 1'b0, 1'b1, "R4 miss2");
    push(2'd0, 32'h3080, 32'h32, 1'b0, 1'b0, "R4 miss refused at cap");
    n0 = nlog;
    push(2'd3, 32'h5000, 32'h50, 1'b1, 1'b1, "R4 hit at cap");
    idle(3);
    chk(nlog == n0 + 1 && log_addr[n0] == 32'h5000, "R4 hit drains", log_addr[n0], 32'h5000);
    fill(32'h3000);
    idle(2);
    push(2'd0, 32'h3080, 32'h32, 1'b0, 1'b1, "R4 miss after release");
    fill(32'h3040);
    fill(32'h3080);
    idle(4);
    chk(nlog == n0 + 4, "R4 all drained", nlog - n0, 4);
  endtask

  task automatic t_clamp_full();
    int n0;
    set_cap(4'd0);
    push(2'd0, 32'h4000, 32'h40, 1'b0, 1'b1, "R5 cap1 first");
    push(2'd0, 32'h4040, 32'h41, 1'b0, 1'b0, "R5 cap1 second refused");
    fill(32'h4000);
    idle(3);
    set_cap(4'd15);
    for (int i = 0; i < DEPTH; i++)
      push(2'd1, 32'h6000 + 32'(i) * 32'h40, 32'h60 + 32'(i), 1'b0, 1'b1, "R5 cap clamped to depth");
    push(2'd2, 32'h7000, 32'h70, 1'b1, 1'b0, "R9 full refuses hit");
    n0 = nlog;
    fill(32'h6000);
    st_valid = 1'b0; pr_hit = 1'b1; st_addr = 32'h7000;
    #1;
    chk(st_ready == 1'b0, "R11 still full before drain", st_ready, 0);
    @(negedge clk);
    #1;
    chk(st_ready == 1'b1, "R11 slot free after drain", st_ready, 1);
    pr_hit = 1'b0;
    push(2'd2, 32'h7000, 32'h70, 1'b1, 1'b1, "R11 reuse slot");
    for (int i = 1; i < DEPTH; i++) fill(32'h6000 + 32'(i) * 32'h40);
    idle(4);
    chk(nlog == n0 + DEPTH + 1, "R11 all drained", nlog - n0, DEPTH + 1);
  endtask

  task automatic t_multi();
    int n0;
    int f;
    set_cap(4'd3);
    push(2'd0, 32'h8000, 32'h80, 1'b0, 1'b1, "R6 m0");
    push(2'd0, 32'h8004, 32'h81, 1'b0, 1'b1, "R6 m1");
    push(2'd0, 32'h8008, 32'h82, 1'b0, 1'b1, "R6 m2");
    push(2'd0, 32'h9000, 32'h90, 1'b0, 1'b0, "R6 cap reached");
    n0 = nlog;
    fill(32'h8000);
    f = last_cyc;
    idle(5);
    chk(nlog == n0 + 3, "R6 one fill releases all", nlog - n0, 3);
    for (int k = 0; k < 3; k++) begin
      chk(log_data[n0+k] == 32'h80 + 32'(k), "R7 oldest first", log_data[n0+k], 32'h80 + k);
      chk(log_cyc[n0+k] - f == 2 + k, "R7 one per cycle", log_cyc[n0+k] - f, 2 + k);
    end
    push(2'd0, 32'hA000, 32'hA0, 1'b0, 1'b1, "R6 count recovered a");
    push(2'd0, 32'hA040, 32'hA1, 1'b0, 1'b1, "R6 count recovered b");
    push(2'd0, 32'hA080, 32'hA2, 1'b0, 1'b1, "R6 count recovered c");
    fill(32'hA000); fill(32'hA040); fill(32'hA080);
    idle(4);
  endtask

  task automatic t_order();
    int n0;
    set_cap(4'd8);
    n0 = nlog;
    push(2'd0, 32'hB000, 32'h1, 1'b0, 1'b1, "R8 older miss");
    push(2'd0, 32'hB000, 32'h2, 1'b1, 1'b1, "R8 younger same thread");
    push(2'd1, 32'hB000, 32'h3, 1'b1, 1'b1, "R8 other thread");
    idle(4);
    chk(nlog == n0 + 1, "R8 only other thread drains", nlog - n0, 1);
    chk(log_data[n0] == 32'h3 && log_tid[n0] == 2'd1, "R8 other thread data", log_data[n0], 3);
    fill(32'hB000);
    idle(4);
    chk(nlog == n0 + 3, "R8 both drain after fill", nlog - n0, 3);
    chk(log_data[n0+1] == 32'h1, "R8 older first", log_data[n0+1], 1);
    chk(log_data[n0+2] == 32'h2, "R8 younger second", log_data[n0+2], 2);
  endtask

  task automatic t_bypass();
    int n0;
    int a;
    set_cap(4'd1);
    push(2'd0, 32'hC000, 32'hC0, 1'b0, 1'b1, "R10 fill cap");
    n0 = nlog;
    offer(2'd1, 32'hD000, 32'hD0, 1'b0, 1'b1, "R10 bypass accepted at cap", 1'b1, 26'h340);
    a = last_cyc;
    idle(3);
    chk(nlog == n0 + 1 && log_addr[n0] == 32'hD000, "R10 drains as hit", log_addr[n0], 32'hD000);
    chk(log_cyc[n0] - a == 2, "R10 latency", log_cyc[n0] - a, 2);
    push(2'd1, 32'hE000, 32'hE0, 1'b0, 1'b0, "R10 count not raised");
    fill(32'hC000);
    idle(3);
    chk(nlog == n0 + 2, "R10 cleanup", nlog - n0, 2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_hit();
    t_miss();
    t_cap();
    t_clamp_full();
    t_multi();
    t_order();
    t_bypass();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule